// File: doc/BRIEF.md
# Bidirectional I/O port with complementary buzzer drive

This block is an I/O port of up to eight lines. Each line has a data latch and a direction latch, and both are written over a small register bus. A line whose direction bit is 0 drives its data bit onto the pad. A line whose direction bit is 1 is an ordinary input.

A static option can hand the two lowest lines to a buzzer. A toggle flip-flop changes state on every timer overflow strobe. When the option is set, line 0 in output mode drives that toggle and line 1 in output mode drives its complement. Data bit 0 alone gates both lines, so software starts and stops the tone with one bit. Lines in input mode are not affected by the option.

Reading the data register returns the actual pad levels, so that bit-manipulation read-modify-write sequences work on what the pins really show. Lines that a parameter marks as absent read as 0 and never drive. A second input-only port is synchronised, can be read back, and raises a one-cycle wake-up request when any of its lines falls.

Top module: `gpio_bz_port`

## Requirements
- R1: After reset every direction bit is 1 (input), every data bit is 1, and the buzzer toggle is 0. Also after reset, pad_oe is 0, wake_req is 0, and a read at address 1 returns IMPL.
- R2: With bz_opt = 0, each implemented line in output mode drives its own data bit, including lines 0 and 1.
- R3: The buzzer toggle inverts once for each clock cycle in which tmr_ovf is 1. Without a strobe it holds its value.
- R4: With bz_opt = 1 and line 0 in output mode, pad_out[0] equals data bit 0 AND the toggle.
- R5: With bz_opt = 1 and line 1 in output mode, pad_out[1] equals data bit 0 AND NOT the toggle. Data bit 1 has no effect.
- R6: A line with direction bit 1 has pad_oe low and pad_out low whatever bz_opt is. A read at address 0 returns pad_in for that line.
- R7: A read at address 0 returns, for each line in output mode, the value the block drives on that pad. Address 0 is the data register, address 1 is the direction register, address 2 reads the synchronised wake-up port, and address 3 reads 0.
- R8: Bits that are 0 in IMPL (default 8'h07) read as 0 at every address, never assert pad_oe, and do not respond to writes.
- R9: A 1-to-0 change on any wk_pad line raises wake_req for exactly one cycle. The pulse is visible in the cycle after the second rising edge that follows the change.
- R10: A 0-to-1 change on a wk_pad line does not raise wake_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 wake-up port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data |
| bz_opt | input | 1 | Static buzzer option for lines 0 and 1 |
| tmr_ovf | input | 1 | Timer overflow strobe |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| wk_pad | input | W | Wake-up port pad levels |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
Four properties are checked on every cycle:
- The two buzzer pads never drive 1 at the same time.
- In plain mode the pads stay still when no write occurs.
- Input-mode lines read back their pad.
- Absent bits stay 0.

The exact toggle count per strobe, the gating of both buzzer pads by data bit 0 alone, and the delay and width of the wake-up pulse are shown only by the bench's sweeps. So are the absence of a wake-up on rising edges and the reset values.

// File: rtl/gpio_bz_port.sv
module gpio_bz_port #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         bz_opt,
  input  logic         tmr_ovf,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] wk_pad,
  output logic         wake_req
);
  logic [W-1:0] dat_q, dir_q, drv, pin_st;
  logic [W-1:0] wk1, wk2, wk3;
  logic         bz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '1;
      dir_q <= '1;
      bz_q  <= 1'b0;
      wk1   <= '1;
      wk2   <= '1;
      wk3   <= '1;
    end else begin
      if (bus_wr && bus_addr == 2'd0) dat_q <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) dir_q <= bus_wdata;
      if (tmr_ovf) bz_q <= ~bz_q;
      wk1 <= wk_pad;
      wk2 <= wk1;
      wk3 <= wk2;
    end
  end

  always_comb begin
    drv = dat_q;
    if (bz_opt) begin
      drv[0] = dat_q[0] & bz_q;
      drv[1] = dat_q[0] & ~bz_q;
    end
  end

  assign pad_oe  = ~dir_q & IMPL;
  assign pad_out = drv & pad_oe;
  assign pin_st  = pad_out | (dir_q & pad_in & IMPL);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = pin_st;
      2'd1:    bus_rdata = dir_q & IMPL;
      2'd2:    bus_rdata = wk2 & IMPL;
      default: bus_rdata = '0;
    endcase
  end

  assign wake_req = |(wk3 & ~wk2 & IMPL);
endmodule

module gpio_bz_port_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = 8'h07
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_rdata,
  input logic         bz_opt,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe
);
  p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bz_opt && pad_oe[0] && pad_oe[1] && pad_out[0]) |-> !pad_out[1]);

  p_plain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bz_opt && !bus_wr) |=> (bz_opt || ($stable(pad_out) && $stable(pad_oe))));

  p_input_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0 && !pad_oe[0] && IMPL[0]) |-> bus_rdata[0] == pad_in[0]);

  p_absent_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL) == '0) && ((pad_oe & ~IMPL) == '0));
endmodule

bind gpio_bz_port gpio_bz_port_chk #(.W(W), .IMPL(IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .bz_opt(bz_opt), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_bz_port.sv
module sim_gpio_bz_port;
  localparam int CLK_P = 10;
  localparam logic [7:0] IM = 8'h07;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bz_opt = 0, tmr_ovf = 0;
  logic [7:0] bus_wdata = 0, pad_in = 0, wk_pad = 8'hFF;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic wake_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic bzm = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_bz_port u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bz_opt(bz_opt), .tmr_ovf(tmr_ovf),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .wk_pad(wk_pad), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    bzm = ~bzm;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    pad_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pad_oe at reset", pad_oe, 8'h00);
    chk("R1 wake_req at reset", wake_req, 0);
    rd(2'd1, r); chk("R1 dir readback", r, IM);
    rd(2'd0, r); chk("R1 input read", r, 8'h5A & IM);
    wr(2'd1, 8'h00);
    chk("R1 data reset ones", pad_out, IM);
    chk("R1 buzzer starts 0 (plain gives 1 on line1)", pad_out[1], 1);

    for (int d = 0; d < 256; d++) begin
      wr(2'd0, d[7:0]);
      chk("R2 plain out", pad_out, d[7:0] & IM);
      chk("R8 oe implemented only", pad_oe, IM);
      rd(2'd0, r); chk("R7 read driven", r, d[7:0] & IM);
      rd(2'd3, r); chk("R7 addr3 zero", r, 0);
    end

    wr(2'd0, 8'hFF);
    for (int dr = 0; dr < 256; dr++) begin
      wr(2'd1, dr[7:0]);
      chk("R6 oe", pad_oe, ~dr[7:0] & IM);
      chk("R6 out", pad_out, ~dr[7:0] & IM);
      rd(2'd0, r); chk("R6 mixed read", r, (~dr[7:0] & IM) | (dr[7:0] & 8'h5A & IM));
      rd(2'd1, r); chk("R8 dir read", r, dr[7:0] & IM);
    end

    wr(2'd1, 8'h00);
    @(negedge clk); bz_opt = 1;
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, d[7:0]);
      for (int k = 0; k < 4; k++) begin
        pulse();
        chk("R3/R4 pad0", pad_out[0], d[0] & bzm);
        chk("R5 pad1", pad_out[1], d[0] & ~bzm);
        rd(2'd0, r); chk("R7 buzzer read", r[1:0], {d[0] & ~bzm, d[0] & bzm});
      end
      repeat (3) @(negedge clk);
      chk("R3 hold without strobe", pad_out[1:0], {d[0] & ~bzm, d[0] & bzm});
    end

    wr(2'd1, 8'h03);
    chk("R6 buzzer input oe", pad_oe, 8'h04);
    chk("R6 buzzer input out", pad_out[1:0], 2'b00);
    pad_in = 8'hFE;
    rd(2'd0, r); chk("R6 buzzer input read", r[1:0], 2'b10);
    @(negedge clk); bz_opt = 0;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wk_pad = 8'hFF & ~(8'h01 << i);
      @(negedge clk);
      chk("R9 not yet", wake_req, 0);
      @(negedge clk);
      chk("R9 pulse", wake_req, IM[i]);
      rd(2'd2, r); chk("R7 wake read", r, wk_pad & IM);
      @(negedge clk);
      chk("R9 one cycle", wake_req, 0);
      wk_pad = 8'hFF;
      repeat (4) begin
        @(negedge clk);
        chk("R10 rising ignored", wake_req, 0);
      end
    end

    finish_up();
  end
endmodule